// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM of 131072 bytes. The host hands over one word per transaction with a request/ready handshake. The controller then produces the chip-select pair, output enable, write enable, address and data-bus drive for that access. Every strobe comes from a register, and each phase lasts a whole number of clock cycles. Those cycle counts are computed at elaboration time from the clock period and from one of four speed grades, always rounding the nanosecond minimum upward and never going below one cycle.

The memory is selected only when the active-low select is low and the active-high select is high. Whenever no access is running, the controller drives both selects to their inactive levels. During a write, the controller keeps its data drivers off until the memory's output turn-off interval after write enable falls. It turns them off again on the same clock edge that raises write enable. A read holds the memory selected with output enable low for the full read cycle. The returned byte is captured on the edge that closes the read and is presented to the host with a one-cycle valid pulse.

A standby input parks the memory deselected while its supply is lowered for data retention. When standby is removed, the controller waits a configurable recovery time, 5 ms by default, before it accepts any access.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `mem_cs1_n`=1, `mem_cs2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `host_rvalid`=0 and `host_ready`=1.
- R2: A request is taken on a rising edge where `host_req`, `host_ready` and not `standby_req` all hold. `host_ready` is low from that edge until the access completes: N_RC cycles for a read and N_WE+N_REC cycles for a write.
- R3: A read keeps `mem_cs1_n`=0, `mem_cs2`=1, `mem_oe_n`=0 and `mem_we_n`=1 for exactly N_RC = ceil(tRC/T) cycles. During that time `mem_addr` equals the requested address.
- R4: The value on `mem_dq_in` at the edge that ends a read appears on `host_rdata`. `host_rvalid` is high for exactly one cycle, the first cycle in which `host_ready` is high again. A write never raises `host_rvalid`.
- R5: A write holds `mem_we_n`=0 with `mem_oe_n`=1 and the address stable for N_WE = N_HZ+N_DAT cycles. Here N_HZ = ceil(tWHZ/T) and N_DAT = max(ceil(tDW/T), ceil(tWP/T)-N_HZ, ceil(tAW/T)-N_HZ).
- R6: `mem_dq_oe` is high only during the last N_DAT cycles of the write-enable pulse, and `mem_dq_out` then carries the write data. It first rises after N_HZ cycles of write enable low. It falls on the same edge on which `mem_we_n` rises.
- R7: After write enable rises, the memory stays selected with both enables high for N_REC = max(ceil(tWR/T), ceil(tRC/T)-N_WE) cycles before `host_ready` returns.
- R8: While idle, a high `standby_req` takes priority over `host_req`. From the next edge, `host_ready` is low and both selects stay inactive. Requests made during standby start no access and raise no `host_rvalid`.
- R9: After `standby_req` falls, `host_ready` stays low for exactly N_WAKE = ceil(WAKE_NS/T) cycles and then rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host requests an access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | DATA_W | Write data |
| host_ready | output | 1 | Controller idle and able to accept |
| host_rdata | output | DATA_W | Captured read data |
| host_rvalid | output | 1 | One-cycle pulse marking new read data |
| standby_req | input | 1 | Hold memory deselected for retention |
| mem_addr | output | ADDR_W | Address to the RAM |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | DATA_W | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for the data-bus drivers |
| mem_dq_in | input | DATA_W | Data from the RAM bus |

## Verification
The properties assume that the host holds `host_addr`, `host_wr` and `host_wdata` steady only around the accepting edge. They also assume that `mem_dq_in` is meaningful only while a read drives output enable low. The bench changes its inputs on falling edges only and releases `host_req` right after acceptance. It raises and drops `standby_req` only while the controller is idle, so the standby property, which reads `host_ready` as idleness, is never triggered mid-access. The bench's model of the memory returns a byte derived from the address, and only while the memory is selected and output enable is low.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WHZ,
        ST_WDAT,
        ST_WREC,
        ST_STBY,
        ST_WAKE
    } ctl_state_e;

    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // read cycle time, also the minimum write cycle time
    function automatic int grade_cycle_ns(input int g);
        case (g)
            1:       return 85;
            2:       return 100;
            3:       return 120;
            default: return 70;
        endcase
    endfunction

    function automatic int grade_we_pulse_ns(input int g);
        case (g)
            1:       return 60;
            2, 3:    return 70;
            default: return 50;
        endcase
    endfunction

    function automatic int grade_data_setup_ns(input int g);
        case (g)
            1:       return 35;
            2:       return 40;
            3:       return 45;
            default: return 30;
        endcase
    endfunction

    function automatic int grade_we_hiz_ns(input int g);
        case (g)
            2:       return 35;
            3:       return 40;
            default: return 30;
        endcase
    endfunction

    function automatic int grade_addr_to_end_ns(input int g);
        case (g)
            1:       return 75;
            2:       return 85;
            3:       return 100;
            default: return 60;
        endcase
    endfunction

    localparam int WRITE_RECOVERY_NS = 5;

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          vld;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = capture;
        if (capture)
            cap_d.data = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cap_q <= '0;
        else
            cap_q <= cap_d;
    end

    assign rdata  = cap_q.data;
    assign rvalid = cap_q.vld;

    // R4
    rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int SPEED_GRADE   = 0,
    parameter int WAKE_NS       = 5_000_000,
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic              standby_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    // cycle counts, each rounded up and at least one
    localparam int N_RC   = ns_to_cycles(grade_cycle_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int N_HZ   = ns_to_cycles(grade_we_hiz_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int N_DAT  = max2(ns_to_cycles(grade_data_setup_ns(SPEED_GRADE), CLK_PERIOD_NS),
                            max2(ns_to_cycles(grade_we_pulse_ns(SPEED_GRADE), CLK_PERIOD_NS) - N_HZ,
                                 ns_to_cycles(grade_addr_to_end_ns(SPEED_GRADE), CLK_PERIOD_NS) - N_HZ));
    localparam int N_WE   = N_HZ + N_DAT;
    localparam int N_REC  = max2(ns_to_cycles(WRITE_RECOVERY_NS, CLK_PERIOD_NS), N_RC - N_WE);
    localparam int N_WAKE = ns_to_cycles(WAKE_NS, CLK_PERIOD_NS);
    localparam int PH_MAX = max2(max2(N_RC, N_HZ), max2(N_DAT, N_REC));
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int WK_W   = $clog2(N_WAKE + 1);

    typedef struct packed {
        ctl_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wd;
        logic              sel;
        logic              oe;
        logic              we;
        logic              drv;
    } ctl_t;

    ctl_t            ctl_d, ctl_q;
    logic            ph_load, ph_expired;
    logic [PH_W-1:0] ph_val;
    logic            wk_load, wk_expired;
    logic            rd_capture;

    sram_phase_timer #(.W(PH_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .expired  (ph_expired)
    );

    sram_phase_timer #(.W(WK_W)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wk_load),
        .load_val (WK_W'(N_WAKE - 1)),
        .expired  (wk_expired)
    );

    sram_rd_capture #(.DW(DATA_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (rd_capture),
        .din     (mem_dq_in),
        .rdata   (host_rdata),
        .rvalid  (host_rvalid)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ph_load    = 1'b0;
        ph_val     = '0;
        wk_load    = 1'b0;
        rd_capture = 1'b0;

        case (ctl_q.st)
            ST_IDLE: begin
                if (standby_req) begin
                    ctl_d.st = ST_STBY;
                end else if (host_req) begin
                    ctl_d.addr = host_addr;
                    ctl_d.wd   = host_wdata;
                    ph_load    = 1'b1;
                    if (host_wr) begin
                        ctl_d.st = ST_WHZ;
                        ph_val   = PH_W'(N_HZ - 1);
                    end else begin
                        ctl_d.st = ST_RD;
                        ph_val   = PH_W'(N_RC - 1);
                    end
                end
            end
            ST_RD: begin
                if (ph_expired) begin
                    rd_capture = 1'b1;
                    ctl_d.st   = ST_IDLE;
                end
            end
            ST_WHZ: begin
                if (ph_expired) begin
                    ctl_d.st = ST_WDAT;
                    ph_load  = 1'b1;
                    ph_val   = PH_W'(N_DAT - 1);
                end
            end
            ST_WDAT: begin
                if (ph_expired) begin
                    ctl_d.st = ST_WREC;
                    ph_load  = 1'b1;
                    ph_val   = PH_W'(N_REC - 1);
                end
            end
            ST_WREC: begin
                if (ph_expired)
                    ctl_d.st = ST_IDLE;
            end
            ST_STBY: begin
                if (!standby_req) begin
                    ctl_d.st = ST_WAKE;
                    wk_load  = 1'b1;
                end
            end
            ST_WAKE: begin
                if (standby_req)
                    ctl_d.st = ST_STBY;
                else if (wk_expired)
                    ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        // strobes follow the next phase so every pin leaves a register
        ctl_d.sel = (ctl_d.st == ST_RD) || (ctl_d.st == ST_WHZ) ||
                    (ctl_d.st == ST_WDAT) || (ctl_d.st == ST_WREC);
        ctl_d.oe  = (ctl_d.st == ST_RD);
        ctl_d.we  = (ctl_d.st == ST_WHZ) || (ctl_d.st == ST_WDAT);
        ctl_d.drv = (ctl_d.st == ST_WDAT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign host_ready = (ctl_q.st == ST_IDLE);
    assign mem_addr   = ctl_q.addr;
    assign mem_cs1_n  = ~ctl_q.sel;
    assign mem_cs2    = ctl_q.sel;
    assign mem_oe_n   = ~ctl_q.oe;
    assign mem_we_n   = ~ctl_q.we;
    assign mem_dq_out = ctl_q.wd;
    assign mem_dq_oe  = ctl_q.drv;

    // R3
    oe_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_cs1_n && mem_cs2 && mem_we_n));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

    // R6
    drive_under_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n));

    // R6
    drive_after_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(!mem_we_n));

    // R6
    release_with_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_dq_oe);

    // R8
    standby_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_req && host_ready) |=> (mem_cs1_n && !mem_cs2 && !host_ready));

endmodule

// File: tb/sram_strobe_ctrl_test.sv
module sram_strobe_ctrl_test;

    localparam int CLK_NS  = 10;
    localparam int WAKE_NS = 1000;
    // expected counts at grade 0 with a 10 ns clock
    localparam int N_RC   = 7;   // 70 ns
    localparam int N_HZ   = 3;   // 30 ns
    localparam int N_DAT  = 3;   // max(30ns->3, 5-3, 6-3)
    localparam int N_WE   = 6;
    localparam int N_REC  = 1;   // max(5ns->1, 7-6)
    localparam int N_WAKE = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [16:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic        standby_req = 1'b0;
    logic [16:0] mem_addr;
    logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out, mem_dq_in;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [7:0] model_byte(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'b0, a[16]} ^ 8'h5A;
    endfunction

    assign mem_dq_in = (!mem_cs1_n && mem_cs2 && !mem_oe_n) ? model_byte(mem_addr) : 8'h00;

    sram_strobe_ctrl #(
        .CLK_PERIOD_NS (CLK_NS),
        .SPEED_GRADE   (0),
        .WAKE_NS       (WAKE_NS)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_req    (host_req),
        .host_wr     (host_wr),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_ready  (host_ready),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .standby_req (standby_req),
        .mem_addr    (mem_addr),
        .mem_cs1_n   (mem_cs1_n),
        .mem_cs2     (mem_cs2),
        .mem_oe_n    (mem_oe_n),
        .mem_we_n    (mem_we_n),
        .mem_dq_out  (mem_dq_out),
        .mem_dq_oe   (mem_dq_oe),
        .mem_dq_in   (mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // {write, address, data}
    localparam int N_OPS = 8;
    localparam logic [25:0] OPS [N_OPS] = '{
        {1'b1, 17'h00000, 8'hA5},
        {1'b0, 17'h00000, 8'h00},
        {1'b1, 17'h1FFFF, 8'h3C},
        {1'b0, 17'h1FFFF, 8'h00},
        {1'b0, 17'h0AAAA, 8'h00},
        {1'b1, 17'h15555, 8'hFF},
        {1'b0, 17'h00001, 8'h00},
        {1'b1, 17'h00002, 8'h00}
    };

    task automatic run_op(input logic wr, input logic [16:0] a, input logic [7:0] d);
        int k, sel_cnt, we_cnt, oe_cnt, drv_cnt, first_drv, bad_addr, bad_data;
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
        k = 0; sel_cnt = 0; we_cnt = 0; oe_cnt = 0; drv_cnt = 0;
        first_drv = -1; bad_addr = 0; bad_data = 0;
        while (!host_ready && k < 1000) begin
            if (!mem_cs1_n && mem_cs2) begin
                sel_cnt++;
                if (mem_addr != a) bad_addr++;
            end
            if (!mem_we_n) we_cnt++;
            if (!mem_oe_n) oe_cnt++;
            if (mem_dq_oe) begin
                if (first_drv < 0) first_drv = k;
                drv_cnt++;
                if (mem_dq_out != d || mem_we_n) bad_data++;
            end
            if (host_rvalid) bad_data++;
            k++;
            @(negedge clk);
        end
        if (!wr) begin
            check(k == N_RC, "R2 read busy cycles", k, N_RC);
            check(oe_cnt == N_RC && sel_cnt == N_RC, "R3 read strobe cycles", oe_cnt, N_RC);
            check(we_cnt == 0 && bad_addr == 0, "R3 read WE/addr errors", we_cnt + bad_addr, 0);
            check(host_rvalid == 1'b1, "R4 rvalid at ready", host_rvalid, 1);
            check(host_rdata == model_byte(a), "R4 rdata", host_rdata, model_byte(a));
            @(negedge clk);
            check(host_rvalid == 1'b0, "R4 rvalid one cycle", host_rvalid, 0);
        end else begin
            check(k == N_WE + N_REC, "R2 write busy cycles", k, N_WE + N_REC);
            check(we_cnt == N_WE && oe_cnt == 0, "R5 WE low cycles", we_cnt, N_WE);
            check(bad_addr == 0, "R5 address held", bad_addr, 0);
            check(drv_cnt == N_DAT, "R6 drive cycles", drv_cnt, N_DAT);
            check(first_drv == N_HZ, "R6 drive start", first_drv, N_HZ);
            check(bad_data == 0, "R6 drive data/overlap", bad_data, 0);
            check(sel_cnt == N_WE + N_REC, "R7 selected through recovery", sel_cnt, N_WE + N_REC);
            check(host_rvalid == 1'b0, "R4 no rvalid on write", host_rvalid, 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int cnt, bad;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe,
              "R1 strobes in reset", {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
        check(host_ready && !host_rvalid, "R1 handshake in reset", {host_ready, host_rvalid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs1_n && !mem_cs2 && host_ready, "R1 after release",
              {mem_cs1_n, mem_cs2, host_ready}, 3'b101);

        // table of accesses
        for (int i = 0; i < N_OPS; i++)
            run_op(OPS[i][25], OPS[i][24:8], OPS[i][7:0]);

        // R8 standby wins over a simultaneous request
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        standby_req = 1'b1; host_req = 1'b1; host_wr = 1'b0; host_addr = 17'h00123;
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (host_ready || !mem_cs1_n || mem_cs2 || !mem_oe_n || !mem_we_n || host_rvalid) bad++;
        end
        check(bad == 0, "R8 standby ignores request", bad, 0);
        host_req = 1'b0;
        standby_req = 1'b0;
        // R9 recovery wait
        cnt = 0;
        @(negedge clk);
        while (!host_ready && cnt < 10000) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == N_WAKE, "R9 wake cycles", cnt, N_WAKE);
        check(!host_rvalid && mem_cs1_n, "R8 no access started", {host_rvalid, mem_cs1_n}, 2'b01);

        // normal operation after wake
        run_op(1'b0, 17'h0F0F0, 8'h00);
        run_op(1'b1, 17'h10001, 8'h81);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule